// File: doc/BRIEF.md
# SDRAM Mode-Register Burst and Latency Engine

This block is the device-side command and data-timing core of a single-data-rate SDRAM model. A host drives one command per clock on `cmd_i` together with an address. The engine keeps a mode word that a LOAD MODE command writes. That word sets the burst length, the column ordering inside a burst, the read latency and whether writes burst at all. A small synthesizable word array stands in for the DRAM cells.

An ACTIVE command selects a row. A READ or WRITE then walks a burst of columns, one beat per clock, and the column order follows the programmed ordering rule. Read words travel through a latency pipeline. The output enable switches on one cycle before the first valid word and stays on through the last one. Writes take `wdata_i` on each beat edge. A mode bit can limit every write to one location while reads keep their full burst.

Top module: `sdr_burst_engine`

## Requirements
- R1: After reset the mode word is burst length 1, sequential order, latency 2, writes bursting. `rdata_oe_o` and `mode_illegal_o` are low.
- R2: Command codes on `cmd_i` are 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE and 4 LOAD MODE. An accepted LOAD MODE copies `addr_i[9:0]` into the mode word. The fields are burst length in bits 2..0, ordering in bit 3 (1 = interleaved), latency in bits 6..4, operating mode in bits 8..7 and single-write in bit 9.
- R3: `mode_illegal_o` is high when bits 8..7 are nonzero, when the burst-length code is above 011, or when the latency code is neither 010 nor 011. While it is high, READ and WRITE are ignored: nothing is written and the output enable stays low.
- R4: Take a READ registered at edge n with latency m (code 010 = 2, 011 = 3). The first word is on `rdata_o` after edge n+m. `rdata_oe_o` rises after edge n+m-1, one cycle before that word.
- R5: `rdata_oe_o` stays high through the last read word and falls after it. A read that starts right after the previous one keeps it high without a gap. `rdata_o` is X whenever no word is valid.
- R6: Burst-length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats, one beat per clock.
- R7: In sequential order, the low log2(length) column bits count up from the start value and wrap within the burst-aligned block. The upper bits stay fixed.
- R8: In interleaved order, the low log2(length) column bits equal the start value XOR the beat number.
- R9: A WRITE burst stores `wdata_i` at each beat edge into the column for that beat. When bit 9 is set, every write stores a single word while reads still burst.
- R10: While a burst is being addressed, every command is ignored. LOAD MODE is also ignored while any read word is still in the pipeline, which means until five edges after the last read beat edge.
- R11: ACTIVE latches the row from `addr_i[1:0]`. Later READ and WRITE bursts use that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 3 | Command code |
| addr_i | input | 10 | Row, column or mode value |
| wdata_i | input | 8 | Write data for the current beat |
| rdata_o | output | 8 | Read data, X when not valid |
| rdata_oe_o | output | 1 | Read output enable |
| mode_illegal_o | output | 1 | Mode word holds a reserved value |

## Verification
The bench first fills the whole array with address-dependent data. It then reads back under six mode words that combine every burst length, both orderings and both latencies. Start columns at zero, odd offsets, the block end and the array end separate a wrapping sequential walk from an XOR walk and from a plain increment. Back-to-back reads show whether the enable stays high across bursts, and isolated reads show that it leads the data by exactly one cycle. Reserved mode words, commands issued during a burst and single-location writes followed by a full read show which stimuli must leave the array and the mode word untouched.

// File: rtl/sdr_engine_pkg.sv
`timescale 1ns/1ps
package sdr_engine_pkg;

  localparam int MODE_W = 10;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_LOAD = 3'd4
  } cmd_e;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] op;
    logic [2:0] cl;
    logic       interleave;
    logic [2:0] bl;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '{wr_single: 1'b0, op: 2'b00, cl: 3'b010,
                                     interleave: 1'b0, bl: 3'b000};

  function automatic logic [3:0] burst_words(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic mode_reserved(input mode_t m);
    return (m.op != 2'b00) || m.bl[2] || !((m.cl == 3'b010) || (m.cl == 3'b011));
  endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
`timescale 1ns/1ps
module sdr_mode_reg
  import sdr_engine_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              busy_i,
  input  logic [MODE_W-1:0] value_i,
  output mode_t             mode_o,
  output logic              illegal_o
);

  mode_t mode_q, mode_d;
  logic  load_en;

  always_comb begin
    load_en = load_i && !busy_i;
    mode_d  = mode_q;
    if (load_en) mode_d = mode_t'(value_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_DEFAULT;
    else if (load_en) mode_q <= mode_d;
  end

  assign mode_o    = mode_q;
  assign illegal_o = mode_reserved(mode_q);

  // R10
  lmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && busy_i) |=> $stable(mode_q));

  // R2
  lmr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_i) |=> (mode_q == mode_t'($past(value_i))));

endmodule

// File: rtl/sdr_burst_addr.sv
`timescale 1ns/1ps
module sdr_burst_addr #(
  parameter int COL_W  = 6,
  parameter int MAX_BL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [$clog2(MAX_BL):0] len_i,
  input  logic             interleave_i,
  output logic             busy_o,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] col_o
);

  localparam int LOW_W = $clog2(MAX_BL);
  localparam int LEN_W = LOW_W + 1;

  logic             busy_q, busy_d;
  logic [LOW_W-1:0] beat_q, beat_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [COL_W-1:0] base_q, base_d;
  logic             ilv_q, ilv_d;

  logic [LOW_W-1:0] beat_cur, mask, low_walk;
  logic [LEN_W-1:0] len_cur;
  logic [COL_W-1:0] base_cur;
  logic             ilv_cur, last_beat;

  always_comb begin
    beat_cur = busy_q ? beat_q : '0;
    len_cur  = busy_q ? len_q  : len_i;
    base_cur = busy_q ? base_q : start_col_i;
    ilv_cur  = busy_q ? ilv_q  : interleave_i;
    mask     = LOW_W'(len_cur - LEN_W'(1));
    low_walk = ilv_cur ? (base_cur[LOW_W-1:0] ^ beat_cur)
                       : (base_cur[LOW_W-1:0] + beat_cur);
    col_o    = {base_cur[COL_W-1:LOW_W],
                (base_cur[LOW_W-1:0] & ~mask) | (low_walk & mask)};
    beat_valid_o = busy_q || start_i;
    last_beat    = (beat_q == LOW_W'(len_q - LEN_W'(1)));
  end

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    len_d  = len_q;
    base_d = base_q;
    ilv_d  = ilv_q;
    if (busy_q) begin
      if (last_beat) busy_d = 1'b0;
      else           beat_d = beat_q + LOW_W'(1);
    end else if (start_i && (len_i > LEN_W'(1))) begin
      busy_d = 1'b1;
      beat_d = LOW_W'(1);
      len_d  = len_i;
      base_d = start_col_i;
      ilv_d  = interleave_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      len_q  <= LEN_W'(1);
      base_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      len_q  <= len_d;
      base_q <= base_d;
      ilv_q  <= ilv_d;
    end
  end

  assign busy_o = busy_q;

  // R6
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, beat_q} < len_q));

  // R6
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (({1'b0, $past(beat_q)} + LEN_W'(1)) == $past(len_q)));

  // R9
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q && (len_i == LEN_W'(1))) |=> !busy_q);

endmodule

// File: rtl/sdr_read_pipe.sv
`timescale 1ns/1ps
module sdr_read_pipe #(
  parameter int DATA_W = 8,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cl3_i,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);

  localparam int DEPTH = MAX_CL + 1;
  localparam int SW    = $clog2(DEPTH);

  logic [DEPTH-1:0]  v_q, v_d;
  logic [DATA_W-1:0] d_q [DEPTH];
  logic [SW-1:0]     sel;
  logic              data_valid;

  always_comb begin
    v_d        = {v_q[DEPTH-2:0], push_i};
    sel        = cl3_i ? SW'(MAX_CL) : SW'(MAX_CL - 1);
    data_valid = v_q[sel];
    oe_o       = v_q[sel] | v_q[SW'(sel - SW'(1))];
    data_o     = data_valid ? d_q[sel] : 'x;
    empty_o    = ~|v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (push_i) d_q[0] <= data_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (v_d[g]) d_q[g] <= d_q[g-1];
    end
  end

  // R4
  oe_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> !data_valid);

  // R5
  oe_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> $past(data_valid));

endmodule

// File: rtl/sdr_burst_engine.sv
`timescale 1ns/1ps
module sdr_burst_engine
  import sdr_engine_pkg::*;
#(
  parameter int ROW_W  = 2,
  parameter int COL_W  = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int MAX_BL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              mode_illegal_o
);

  localparam int WORDS = 1 << (ROW_W + COL_W);
  localparam int LEN_W = $clog2(MAX_BL) + 1;

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  cmd_e             cmd;
  mode_t            mode;
  logic             illegal, burst_busy, pipe_empty, beat_valid;
  logic             start, cur_wr, wr_q, act_en, push;
  logic [LEN_W-1:0] len;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row_q;
  logic [ROW_W+COL_W-1:0] idx;
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    cmd    = cmd_e'(cmd_i);
    act_en = (cmd == CMD_ACT) && !burst_busy;
    start  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && !burst_busy && !illegal;
    len    = ((cmd == CMD_WR) && mode.wr_single) ? LEN_W'(1) : LEN_W'(burst_words(mode.bl));
    cur_wr = burst_busy ? wr_q : (cmd == CMD_WR);
    idx    = {row_q, col};
    push   = beat_valid && !cur_wr;
    rd_word = mem_q[idx];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      row_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      if (act_en) row_q <= addr_i[ROW_W-1:0];
      if (start)  wr_q  <= (cmd == CMD_WR);
    end
  end

  always_ff @(posedge clk) begin
    if (beat_valid && cur_wr) mem_q[idx] <= wdata_i;
  end

  sdr_mode_reg i_mode (
    .clk       (clk),
    .rst_n     (srst_n),
    .load_i    (cmd == CMD_LOAD),
    .busy_i    (burst_busy || !pipe_empty),
    .value_i   (addr_i[MODE_W-1:0]),
    .mode_o    (mode),
    .illegal_o (illegal)
  );

  sdr_burst_addr #(.COL_W(COL_W), .MAX_BL(MAX_BL)) i_addr (
    .clk          (clk),
    .rst_n        (srst_n),
    .start_i      (start),
    .start_col_i  (addr_i[COL_W-1:0]),
    .len_i        (len),
    .interleave_i (mode.interleave),
    .busy_o       (burst_busy),
    .beat_valid_o (beat_valid),
    .col_o        (col)
  );

  sdr_read_pipe #(.DATA_W(DATA_W), .MAX_CL(3)) i_pipe (
    .clk     (clk),
    .rst_n   (srst_n),
    .push_i  (push),
    .data_i  (rd_word),
    .cl3_i   (mode.cl == 3'b011),
    .oe_o    (rdata_oe_o),
    .data_o  (rdata_o),
    .empty_o (pipe_empty)
  );

  assign mode_illegal_o = illegal;

  // R3
  illegal_block_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (illegal && !burst_busy) |-> !beat_valid);

  // R11
  row_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    burst_busy |=> $stable(row_q));

endmodule

// File: tb/test_sdr_burst_engine.sv
`timescale 1ns/1ps
module test_sdr_burst_engine;

  localparam int MAXC = 40000;

  logic       clk, rst_n;
  logic [2:0] cmd;
  logic [9:0] addr;
  logic [7:0] wd;
  logic [7:0] rdata;
  logic       oe, illegal;

  sdr_burst_engine i_sdr_burst_engine (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .rdata_oe_o(oe), .mode_illegal_o(illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    nchk = 0, nfail = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // reference model state
  int         e = 0;
  logic [9:0] m_mode = 10'h020;
  int         m_row = 0, m_busy = 0, m_beat = 0, m_bl = 1, m_base = 0, m_ilv = 0;
  int         m_wr = 0, m_cl = 2, last_rd = -100;
  int         mem [256];
  bit         exp_v [MAXC];
  logic [7:0] exp_d [MAXC];

  function automatic bit reserved_mode(input logic [9:0] v);
    return (v[8:7] != 0) || (v[2:0] > 3) || ((v[6:4] != 2) && (v[6:4] != 3));
  endfunction

  function automatic int beat_col(input int base, input int bl, input int ilv, input int k);
    int off;
    off = base % bl;
    if (ilv != 0) return base - off + (off ^ k);
    return base - off + ((off + k) % bl);
  endfunction

  task automatic model_beat(input int k);
    int c;
    c = beat_col(m_base, m_bl, m_ilv, k);
    if (m_wr != 0) mem[m_row * 64 + c] = int'(wd);
    else begin
      exp_v[e + m_cl] = 1'b1;
      exp_d[e + m_cl] = 8'(mem[m_row * 64 + c]);
      last_rd = e;
    end
  endtask

  always @(posedge clk) begin
    e++;
    if (!rst_n) begin
      m_mode = 10'h020; m_row = 0; m_busy = 0; last_rd = -100;
    end else if (m_busy != 0) begin
      model_beat(m_beat);
      m_beat++;
      if (m_beat == m_bl) m_busy = 0;
    end else begin
      case (cmd)
        3'd1: m_row = int'(addr) % 4;
        3'd2, 3'd3: if (!reserved_mode(m_mode)) begin
          m_wr   = (cmd == 3'd3) ? 1 : 0;
          m_base = int'(addr) % 64;
          m_bl   = (m_wr != 0 && m_mode[9]) ? 1 : (1 << m_mode[2:0]);
          m_ilv  = m_mode[3] ? 1 : 0;
          m_cl   = (m_mode[6:4] == 3) ? 3 : 2;
          model_beat(0);
          if (m_bl > 1) begin m_busy = 1; m_beat = 1; end
        end
        3'd4: if (e - last_rd >= 5) m_mode = addr;
        default: ;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      nchk++;
      if (oe !== (exp_v[e] || exp_v[e + 1])) begin
        nfail++;
        $display("FAIL %s R4 R5 cycle %0d rdata_oe_o=%0b expected %0b", cur_req, e, oe,
                 exp_v[e] || exp_v[e + 1]);
      end
      nchk++;
      if (illegal !== reserved_mode(m_mode)) begin
        nfail++;
        $display("FAIL %s R3 cycle %0d mode_illegal_o=%0b expected %0b", cur_req, e, illegal,
                 reserved_mode(m_mode));
      end
      if (exp_v[e]) begin
        nchk++;
        if (rdata !== exp_d[e]) begin
          nfail++;
          $display("FAIL %s cycle %0d rdata_o=%h expected %h", cur_req, e, rdata, exp_d[e]);
        end
      end
    end
  end

  task automatic cyc(input logic [2:0] c, input logic [9:0] a, input logic [7:0] d);
    @(posedge clk); #5;
    cmd = c; addr = a; wd = d;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) cyc(3'd0, 10'd0, 8'd0);
  endtask

  task automatic load_mode(input logic [9:0] v);
    cyc(3'd4, v, 8'd0);
    nops(2);
  endtask

  task automatic wr_burst(input int col, input int n, input int seed);
    cyc(3'd3, 10'(col), 8'(seed));
    for (int k = 1; k < n; k++) cyc(3'd0, 10'd0, 8'(seed + k * 7));
  endtask

  task automatic rd_burst(input int col, input int n);
    cyc(3'd2, 10'(col), 8'd0);
    for (int k = 1; k < n; k++) cyc(3'd0, 10'd0, 8'd0);
  endtask

  task automatic check_flag(input logic act, input logic exp, input string tag);
    @(negedge clk); #1;
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s flag=%0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog run did not complete: actual hung expected done");
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin : stim
    logic [9:0] rmodes [6];
    int         starts [8];
    int         bl;
    rmodes = '{10'h020, 10'h031, 10'h022, 10'h03A, 10'h02B, 10'h033};
    starts = '{0, 3, 5, 6, 7, 13, 42, 63};
    rst_n = 1'b0; cmd = 3'd0; addr = 10'd0; wd = 8'd0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    nops(4);

    // R1: reset state and default single-beat, latency-2 access
    cur_req = "R1";
    check_flag(oe, 1'b0, "R1 rdata_oe_o");
    check_flag(illegal, 1'b0, "R1 mode_illegal_o");
    wr_burst(2, 1, 8'h3C);
    rd_burst(2, 1);
    nops(6);

    // R2 R9 R11: fill all rows with sequential 8-beat writes
    cur_req = "R2 R9 R11";
    load_mode(10'h023);
    for (int r = 0; r < 4; r++) begin
      cyc(3'd1, 10'(r), 8'd0);
      for (int c = 0; c < 64; c += 8) wr_burst(c, 8, (r * 64 + c) ^ 8'h5A);
    end
    nops(4);

    // R4 R5 R6 R7 R8: every length, both orders, both latencies
    cur_req = "R4 R5 R6 R7 R8 R11";
    for (int mi = 0; mi < 6; mi++) begin
      load_mode(rmodes[mi]);
      bl = 1 << rmodes[mi][2:0];
      cyc(3'd1, 10'(mi % 4), 8'd0);
      for (int s = 0; s < 8; s++) rd_burst(starts[s], bl);
      nops(3);
      for (int s = 0; s < 4; s++) begin
        rd_burst(starts[s * 2 + 1], bl);
        nops(s + 1);
      end
      nops(8);
    end

    // R9: single-location writes with burst reads
    cur_req = "R9";
    load_mode(10'h223);
    cyc(3'd1, 10'd1, 8'd0);
    wr_burst(9, 8, 8'hC3);
    nops(3);
    wr_burst(22, 1, 8'h81);
    nops(2);
    rd_burst(8, 8);
    rd_burst(16, 8);
    nops(8);

    // R3: reserved mode words block accesses
    cur_req = "R3";
    load_mode(10'h0A3);
    check_flag(illegal, 1'b1, "R3 op bits");
    wr_burst(10, 8, 8'hEE);
    rd_burst(10, 8);
    nops(6);
    load_mode(10'h024);
    check_flag(illegal, 1'b1, "R3 length code");
    rd_burst(11, 4);
    nops(4);
    load_mode(10'h013);
    check_flag(illegal, 1'b1, "R3 latency code");
    wr_burst(12, 1, 8'h11);
    nops(4);
    load_mode(10'h023);
    check_flag(illegal, 1'b0, "R3 legal again");
    rd_burst(8, 8);
    nops(8);

    // R10: commands during a burst and LOAD MODE while the pipe drains
    cur_req = "R10";
    cyc(3'd2, 10'd40, 8'd0);
    cyc(3'd0, 10'd0, 8'd0);
    cyc(3'd4, 10'h021, 8'd0);
    cyc(3'd2, 10'd0, 8'd0);
    cyc(3'd1, 10'd3, 8'd0);
    cyc(3'd3, 10'd40, 8'h99);
    cyc(3'd0, 10'd0, 8'd0);
    cyc(3'd0, 10'd0, 8'd0);
    cyc(3'd4, 10'h032, 8'd0);
    nops(2);
    cyc(3'd4, 10'h02A, 8'd0);
    nops(2);
    rd_burst(40, 8);
    rd_burst(45, 4);
    nops(8);

    // R11: row selection
    cur_req = "R11";
    load_mode(10'h022);
    for (int r = 0; r < 4; r++) begin
      cyc(3'd1, 10'(r), 8'd0);
      rd_burst(33, 4);
    end
    nops(8);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule